// File: doc/BRIEF.md
# Segmented Base-Bound Address Relocation and Protection Unit

This block relocates and guards memory accesses using a small bank of segment registers. Each segment, such as code, heap or stack, has a base that says where it sits in physical memory and a bound that limits how far an offset may reach into it. An access supplies an offset, a segment index and the current privilege mode. One cycle later the block returns the relocated physical address, together with a flag that is raised when the offset lies outside the segment.

Only the supervisor can program the segment registers. A write attempt made in user mode changes nothing and raises a one-cycle privilege fault. Supervisor accesses skip relocation altogether and reach physical memory directly. After reset every bound is zero, so each user access faults until the operating system has set up the segments.

Top module: `seg_guard`

## Requirements
- R1: After reset, `rsp_valid_o`, `rsp_fault_o`, `priv_fault_o` and `rsp_paddr_o` are all zero, and every base and bound is zero, so a user access to any segment faults.
- R2: A request sampled with `req_valid_i` high yields `rsp_valid_o` high on the following cycle only; with no request, `rsp_valid_o` is low on the next cycle.
- R3: For a user request (`mode_kernel_i` = 0) with offset below the selected bound, `rsp_paddr_o` = base + offset modulo 2^PA_W and `rsp_fault_o` = 0.
- R4: For a user request whose offset is greater than or equal to the selected bound (unsigned compare), `rsp_fault_o` = 1 and `rsp_paddr_o` = 0.
- R5: For a kernel request (`mode_kernel_i` = 1), `rsp_paddr_o` equals the zero-extended offset and `rsp_fault_o` = 0, whatever the segment registers hold.
- R6: A kernel write (`wr_en_i` = 1, `mode_kernel_i` = 1) loads `wr_data_i` into the base (`wr_field_i` = 0) or the bound (`wr_field_i` = 1, low VA_W bits) of segment `wr_seg_i`. Requests issued from the next cycle onward see the new value.
- R7: A user write (`wr_en_i` = 1, `mode_kernel_i` = 0) changes no register and drives `priv_fault_o` high for exactly the next cycle.
- R8: A kernel write to one segment leaves the base and bound of every other segment unchanged.
- R9: While `rsp_valid_o` is low, `rsp_fault_o` and `rsp_paddr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_kernel_i | input | 1 | Current privilege: 1 = supervisor, 0 = user |
| req_valid_i | input | 1 | Access request strobe |
| req_seg_i | input | SEG_W | Segment index of the access |
| req_vaddr_i | input | VA_W | Offset issued by the program |
| wr_en_i | input | 1 | Segment register write strobe |
| wr_seg_i | input | SEG_W | Segment index to write |
| wr_field_i | input | 1 | 0 = base, 1 = bound |
| wr_data_i | input | PA_W | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_paddr_o | output | PA_W | Relocated physical address, zero on fault |
| rsp_fault_o | output | 1 | Protection violation for the response |
| priv_fault_o | output | 1 | One-cycle pulse after a rejected user write |

## Verification
The assertions assume that `mode_kernel_i` governs the request and the write sampled in the same cycle. They also assume that PA_W is at least VA_W, so that the kernel bypass zero-extends the offset instead of cutting it short. The stimulus changes inputs only on the falling edge and only at default widths. It programs every segment in kernel mode before the vector table runs. User write attempts appear only in directed tests, where the bench then reads the affected segment back through a normal access.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic {
    FLD_BASE  = 1'b0,
    FLD_BOUND = 1'b1
  } seg_field_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             kernel_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  seg_field_e       wr_field_i,
  input  logic [PA_W-1:0]  wr_data_i,
  input  logic [SEG_W-1:0] rd_seg_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [VA_W-1:0]  rd_bound_o
);
  logic [NUM_SEG-1:0][PA_W-1:0] base_q;
  logic [NUM_SEG-1:0][VA_W-1:0] bound_q;
  logic                         wr_ok;

  assign wr_ok = wr_en_i && kernel_i;

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic hit;
    assign hit = wr_ok && (wr_seg_i == SEG_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[s]  <= '0;
        bound_q[s] <= '0;
      end else if (hit) begin
        if (wr_field_i == FLD_BASE) base_q[s]  <= wr_data_i;
        else                        bound_q[s] <= wr_data_i[VA_W-1:0];
      end
    end

    // R8: a write aimed elsewhere leaves this segment alone
    a_r8_other_seg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wr_seg_i != SEG_W'(s))) |=> ($stable(base_q[s]) && $stable(bound_q[s])));
  end

  // out-of-range index reads as bound 0, so user access faults
  always_comb begin
    rd_base_o  = '0;
    rd_bound_o = '0;
    if (int'(rd_seg_i) < NUM_SEG) begin
      rd_base_o  = base_q[rd_seg_i];
      rd_bound_o = bound_q[rd_seg_i];
    end
  end

  a_r7_user_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !kernel_i) |=> ($stable(base_q) && $stable(bound_q)));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            kernel_i,
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [PA_W-1:0] base_i,
  input  logic [VA_W-1:0] bound_i,
  output logic [PA_W-1:0] paddr_o,
  output logic            fault_o
);
  logic [PA_W-1:0] va_ext;
  logic            out_of_seg;

  assign va_ext     = PA_W'(vaddr_i);
  assign out_of_seg = !(vaddr_i < bound_i);

  always_comb begin
    if (kernel_i) begin
      paddr_o = va_ext;
      fault_o = 1'b0;
    end else if (out_of_seg) begin
      paddr_o = '0;
      fault_o = 1'b1;
    end else begin
      paddr_o = base_i + va_ext;
      fault_o = 1'b0;
    end
  end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 4,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_kernel_i,
  input  logic             req_valid_i,
  input  logic [SEG_W-1:0] req_seg_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_seg_i,
  input  logic             wr_field_i,
  input  logic [PA_W-1:0]  wr_data_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             priv_fault_o
);
  logic [PA_W-1:0] sel_base;
  logic [VA_W-1:0] sel_bound;
  logic [PA_W-1:0] xl_paddr;
  logic            xl_fault;
  logic            valid_q, fault_q, priv_q;
  logic [PA_W-1:0] paddr_q;

  seg_regfile #(.NUM_SEG(NUM_SEG), .VA_W(VA_W), .PA_W(PA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .kernel_i   (mode_kernel_i),
    .wr_seg_i   (wr_seg_i),
    .wr_field_i (seg_field_e'(wr_field_i)),
    .wr_data_i  (wr_data_i),
    .rd_seg_i   (req_seg_i),
    .rd_base_o  (sel_base),
    .rd_bound_o (sel_bound)
  );

  seg_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .kernel_i (mode_kernel_i),
    .vaddr_i  (req_vaddr_i),
    .base_i   (sel_base),
    .bound_i  (sel_bound),
    .paddr_o  (xl_paddr),
    .fault_o  (xl_fault)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
      priv_q  <= 1'b0;
    end else begin
      valid_q <= req_valid_i;
      fault_q <= req_valid_i && xl_fault;
      paddr_q <= req_valid_i ? xl_paddr : '0;
      priv_q  <= wr_en_i && !mode_kernel_i;
    end
  end

  assign rsp_valid_o  = valid_q;
  assign rsp_fault_o  = fault_q;
  assign rsp_paddr_o  = paddr_q;
  assign priv_fault_o = priv_q;

  a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  a_r5_kernel_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mode_kernel_i) |=>
      (!rsp_fault_o && (rsp_paddr_o == $past(PA_W'(req_vaddr_i)))));
  a_r4_fault_clears_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_valid_o && (rsp_paddr_o == '0)));
  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_fault_o && (rsp_paddr_o == '0)));
  a_r7_priv_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !mode_kernel_i) |=> priv_fault_o);
  a_r7_priv_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !mode_kernel_i) |=> !priv_fault_o);
endmodule

// File: tb/seg_guard_tb.sv
module seg_guard_tb;
  localparam int NUM_SEG = 4;
  localparam int VA_W    = 32;
  localparam int PA_W    = 32;
  localparam int SEG_W   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             kern = 1'b0;
  logic             req_v = 1'b0;
  logic [SEG_W-1:0] req_seg = '0;
  logic [VA_W-1:0]  req_va = '0;
  logic             wr_en = 1'b0;
  logic [SEG_W-1:0] wr_seg = '0;
  logic             wr_fld = 1'b0;
  logic [PA_W-1:0]  wr_dat = '0;
  logic             rsp_v, rsp_f, priv_f;
  logic [PA_W-1:0]  rsp_pa;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_guard #(.NUM_SEG(NUM_SEG), .VA_W(VA_W), .PA_W(PA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_kernel_i(kern),
    .req_valid_i(req_v), .req_seg_i(req_seg), .req_vaddr_i(req_va),
    .wr_en_i(wr_en), .wr_seg_i(wr_seg), .wr_field_i(wr_fld), .wr_data_i(wr_dat),
    .rsp_valid_o(rsp_v), .rsp_paddr_o(rsp_pa), .rsp_fault_o(rsp_f), .priv_fault_o(priv_f)
  );

  typedef struct packed {
    logic             kern;
    logic [SEG_W-1:0] seg;
    logic [VA_W-1:0]  va;
    logic             exp_fault;
    logic [PA_W-1:0]  exp_pa;
  } vec_t;

  // segments: 0 base 1000_0000 bound 100; 1 base 2000_0000 bound 1_0000;
  // 2 base FFFF_FF00 bound 200; 3 base 0 bound FFFF_FFFF
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 32'h0000_0000, 1'b0, 32'h1000_0000},
    '{1'b0, 2'd0, 32'h0000_00FF, 1'b0, 32'h1000_00FF},
    '{1'b0, 2'd0, 32'h0000_0100, 1'b1, 32'h0000_0000},
    '{1'b0, 2'd1, 32'h0000_FFFF, 1'b0, 32'h2000_FFFF},
    '{1'b0, 2'd1, 32'h8000_0000, 1'b1, 32'h0000_0000},
    '{1'b0, 2'd2, 32'h0000_0180, 1'b0, 32'h0000_0080},
    '{1'b0, 2'd3, 32'hFFFF_FFFE, 1'b0, 32'hFFFF_FFFE},
    '{1'b0, 2'd3, 32'hFFFF_FFFF, 1'b1, 32'h0000_0000},
    '{1'b1, 2'd0, 32'h1234_5678, 1'b0, 32'h1234_5678},
    '{1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF}
  };

  task automatic chk(input string req, input logic [PA_W-1:0] act, input logic [PA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic k, input logic [SEG_W-1:0] s, input logic [VA_W-1:0] va);
    @(negedge clk);
    kern = k; req_v = 1'b1; req_seg = s; req_va = va;
    @(posedge clk); #1;
    req_v = 1'b0;
  endtask

  task automatic write(input logic k, input logic [SEG_W-1:0] s, input logic f, input logic [PA_W-1:0] d);
    @(negedge clk);
    kern = k; wr_en = 1'b1; wr_seg = s; wr_fld = f; wr_dat = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    req_v = 1'b0; wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: state held in reset
    chk("R1 valid in reset", 32'(rsp_v), 32'd0);
    chk("R1 fault in reset", 32'(rsp_f), 32'd0);
    chk("R1 priv in reset", 32'(priv_f), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    chk("R1 paddr after reset", rsp_pa, 32'd0);
    // R1: zero bounds make every user access fault
    for (int s = 0; s < NUM_SEG; s++) begin
      access(1'b0, SEG_W'(s), 32'd0);
      chk("R1 unprogrammed fault", 32'(rsp_f), 32'd1);
    end
    // R2: response strobe lasts a single cycle
    idle();
    chk("R2 idle valid", 32'(rsp_v), 32'd0);
    chk("R9 idle fault", 32'(rsp_f), 32'd0);

    // R6: program all segments in kernel mode
    write(1'b1, 2'd0, 1'b0, 32'h1000_0000);
    write(1'b1, 2'd0, 1'b1, 32'h0000_0100);
    write(1'b1, 2'd1, 1'b0, 32'h2000_0000);
    write(1'b1, 2'd1, 1'b1, 32'h0001_0000);
    write(1'b1, 2'd2, 1'b0, 32'hFFFF_FF00);
    write(1'b1, 2'd2, 1'b1, 32'h0000_0200);
    write(1'b1, 2'd3, 1'b0, 32'h0000_0000);
    write(1'b1, 2'd3, 1'b1, 32'hFFFF_FFFF);
    chk("R7 kernel write no priv fault", 32'(priv_f), 32'd0);

    // R3 R4 R5: table walk
    for (int i = 0; i < NV; i++) begin
      string tag;
      access(VECS[i].kern, VECS[i].seg, VECS[i].va);
      tag = VECS[i].kern ? "R5" : (VECS[i].exp_fault ? "R4" : "R3");
      chk($sformatf("%s vec %0d valid", tag, i), 32'(rsp_v), 32'd1);
      chk($sformatf("%s vec %0d fault", tag, i), 32'(rsp_f), 32'(VECS[i].exp_fault));
      chk($sformatf("%s vec %0d paddr", tag, i), rsp_pa, VECS[i].exp_pa);
    end
    idle();
    chk("R2 valid drops", 32'(rsp_v), 32'd0);
    chk("R9 paddr idle", rsp_pa, 32'd0);

    // R7: user write ignored, one-cycle privilege fault
    write(1'b0, 2'd1, 1'b0, 32'h5555_0000);
    chk("R7 priv fault pulse", 32'(priv_f), 32'd1);
    idle();
    chk("R7 priv fault ends", 32'(priv_f), 32'd0);
    access(1'b0, 2'd1, 32'h0000_0010);
    chk("R7 base unchanged", rsp_pa, 32'h2000_0010);
    write(1'b0, 2'd0, 1'b1, 32'hFFFF_FFFF);
    access(1'b0, 2'd0, 32'h0000_0100);
    chk("R7 bound unchanged", 32'(rsp_f), 32'd1);

    // R6: new bound visible to the next request; R8 neighbours untouched
    write(1'b1, 2'd0, 1'b1, 32'h0000_0101);
    access(1'b0, 2'd0, 32'h0000_0100);
    chk("R6 new bound fault", 32'(rsp_f), 32'd0);
    chk("R6 new bound paddr", rsp_pa, 32'h1000_0100);
    write(1'b1, 2'd2, 1'b0, 32'h0000_4000);
    access(1'b0, 2'd1, 32'h0000_0020);
    chk("R8 seg1 base kept", rsp_pa, 32'h2000_0020);
    access(1'b0, 2'd3, 32'h0000_0040);
    chk("R8 seg3 base kept", rsp_pa, 32'h0000_0040);
    access(1'b0, 2'd2, 32'h0000_0004);
    chk("R6 new base used", rsp_pa, 32'h0000_4004);

    // R1: reset mid-run clears the segments
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 2'd1, 32'h0000_0000);
    chk("R1 bounds cleared by reset", 32'(rsp_f), 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule